// File: doc/BRIEF.md
# Prescaled Reloading Timer

This peripheral keeps two independent time bases behind a small byte-wide register window. A free-running divider byte advances once every 256 tick pulses and is cleared by any store to its address. Beside it runs an 8-bit up-counter whose pace comes from a prescaler. A 2-bit field in the control byte picks that prescaler's period, and another control bit gates it on or off. When the counter rolls past its top value, it reloads from a programmable reload byte and latches a sticky interrupt flag. The flag holds until the host acknowledges it.

The host reaches the four bytes through an address, a write strobe and write data, and gets combinational read data back. The `tick` input is the time base: each clock edge with `tick` high counts as one input cycle. The block has no state machine. Control is carried by three registers (divider, counter and interrupt flag) and two prescale sub-counters.

Top module: `prescaled_timer`

## Requirements
- R1: The window decodes 0xFF04 as the divider, 0xFF05 as the counter, 0xFF06 as the reload byte and 0xFF07 as the control byte. A store to the counter, reload or control address takes effect at the next clock edge, and read data follows the address combinationally.
- R2: The divider byte rises by one on every 256th tick, counted by a separate sub-counter, and wraps from 0xFF to 0x00.
- R3: A store to the divider address sets the divider to zero whatever the data, overriding a same-edge increment. It leaves the divider's sub-counter running undisturbed.
- R4: The control byte uses bits [1:0] to choose the counter period in ticks (00 gives 1024, 01 gives 16, 10 gives 64, 11 gives 256) and bit 2 to enable the counter.
- R5: Reading the control address returns the stored bits [2:0], with bits [7:3] always read as 1.
- R6: When a period completes and the counter holds 0xFF, the counter takes the reload byte's value and the interrupt flag is set.
- R7: When a period completes and the counter holds any other value, the counter rises by one.
- R8: The interrupt flag stays high until an edge with `irq_ack` high. A new overflow on the same edge as an acknowledge leaves the flag set.
- R9: After reset, every register and sub-counter is zero, the counter is disabled and the period selection is 1024. The control byte therefore reads 0xF8.
- R10: An address outside the window reads as 0xFF, and a store to it changes nothing.
- R11: The prescale sub-counter advances only on ticks while the counter is enabled, and holds otherwise. A period completes on an enabled tick edge where the sub-counter already holds period−1 or more; the sub-counter then restarts at zero. A divider clear does not touch it.
- R12: When a store to the counter address falls on the same edge as a completed period, the stored value wins. If the counter held 0xFF, the interrupt flag is still set.
- R13: With `tick` low, neither the divider, the counter nor either sub-counter moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Advance-by-one-input-cycle strobe |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq_ack | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of functions can land on the same edge: a host store to the counter against a completed prescale period, and an acknowledge against a fresh overflow. The bench tracks the prescale residue in its own model. It runs ticks until that model predicts the next enabled tick completes a period, then issues the store or the acknowledge together with that tick. It judges the outcome by the counter value and the flag state read back on the following cycle: the stored byte must win, and the flag must be set. A divider clear against a running divider is provoked the same way, and the check confirms the divider's sub-counter phase survives the clear.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    typedef enum logic [1:0] {
        REG_DIV = 2'd0,
        REG_CNT = 2'd1,
        REG_RLD = 2'd2,
        REG_CTL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    // log2 of the counter period for a 2-bit select: 0->10, 1->4, 2->6, 3->8
    function automatic int unsigned period_log(input logic [1:0] s);
        return (s == 2'd0) ? 32'd10 : (32'd2 + 32'd2 * 32'(s));
    endfunction

endpackage

// File: rtl/tmr_divider.sv
`timescale 1ns/1ps
module tmr_divider #(
    parameter int DATA_W  = 8,
    parameter int SUB_W   = 16,
    parameter int DIV_LOG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    output logic [DATA_W-1:0] div_q
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'((32'd1 << DIV_LOG) - 32'd1);

    logic [SUB_W-1:0] sub_q;
    logic             step;

    assign step = tick && (sub_q == SUB_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (tick) begin
            sub_q <= step ? '0 : sub_q + SUB_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else if (step) begin
            div_q <= div_q + DATA_W'(1);
        end
    end

    // R3
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (div_q == '0));

    // R2
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(div_q));

    // R13
    div_sub_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sub_q));

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PSC_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic [1:0]        psel,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    input  logic [DATA_W-1:0] reload,
    input  logic              ack,
    output logic [DATA_W-1:0] cnt_q,
    output logic              irq_q
);
    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] last_v;
    logic             fire;
    logic             wrap;

    assign last_v = PSC_W'((32'd1 << period_log(psel)) - 32'd1);
    assign fire   = en && tick && (psc_q >= last_v);
    assign wrap   = fire && (&cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (en && tick) begin
            psc_q <= fire ? '0 : psc_q + PSC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (fire) begin
            cnt_q <= wrap ? reload : cnt_q + DATA_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (wrap) begin
            irq_q <= 1'b1;
        end else if (ack) begin
            irq_q <= 1'b0;
        end
    end

    // R11
    psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && tick) |=> $stable(psc_q));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ld) |=> (cnt_q == $past(reload)));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack) |=> irq_q);

    // R12
    store_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt_q == $past(ld_val)));

    // R7
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !fire) |=> $stable(cnt_q));

endmodule

// File: rtl/prescaled_timer.sv
`timescale 1ns/1ps
module prescaled_timer
    import tmr_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter logic [15:0]     BASE_ADDR = 16'hFF04,
    parameter int              SUB_W     = 16,
    parameter int              DIV_LOG   = 8,
    parameter int              PSC_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_ack,
    output logic              irq_flag
);
    localparam int CTL_W = 3;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    reg_dec_t          dec;
    logic [CTL_W-1:0]  ctl_q;
    logic [DATA_W-1:0] rld_q;
    logic [DATA_W-1:0] div_v;
    logic [DATA_W-1:0] cnt_v;
    logic              wr_div, wr_cnt, wr_rld, wr_ctl;

    always_comb begin
        dec.hit = (bus_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
        dec.sel = reg_sel_e'(bus_addr[1:0]);
    end

    assign wr_div = bus_wr && dec.hit && (dec.sel == REG_DIV);
    assign wr_cnt = bus_wr && dec.hit && (dec.sel == REG_CNT);
    assign wr_rld = bus_wr && dec.hit && (dec.sel == REG_RLD);
    assign wr_ctl = bus_wr && dec.hit && (dec.sel == REG_CTL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            rld_q <= '0;
        end else begin
            if (wr_ctl) ctl_q <= bus_wdata[CTL_W-1:0];
            if (wr_rld) rld_q <= bus_wdata;
        end
    end

    tmr_divider #(
        .DATA_W (DATA_W),
        .SUB_W  (SUB_W),
        .DIV_LOG(DIV_LOG)
    ) u_divider (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .clr  (wr_div),
        .div_q(div_v)
    );

    tmr_counter #(
        .DATA_W(DATA_W),
        .PSC_W (PSC_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .en    (ctl_q[2]),
        .psel  (ctl_q[1:0]),
        .ld    (wr_cnt),
        .ld_val(bus_wdata),
        .reload(rld_q),
        .ack   (irq_ack),
        .cnt_q (cnt_v),
        .irq_q (irq_flag)
    );

    always_comb begin
        bus_rdata = '1;
        if (dec.hit) begin
            unique case (dec.sel)
                REG_DIV: bus_rdata = div_v;
                REG_CNT: bus_rdata = cnt_v;
                REG_RLD: bus_rdata = rld_q;
                REG_CTL: bus_rdata = {{(DATA_W-CTL_W){1'b1}}, ctl_q};
            endcase
        end
    end

    // R5
    ctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.hit && dec.sel == REG_CTL) |-> (bus_rdata[DATA_W-1:CTL_W] == '1));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.hit |-> (bus_rdata == '1));

    // R1
    rld_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rld |=> (rld_q == $past(bus_wdata)));

endmodule

// File: tb/prescaled_timer_tb.sv
`timescale 1ns/1ps
module prescaled_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_flag;

    always #2.5 clk = ~clk;

    prescaled_timer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_ack  (irq_ack),
        .irq_flag (irq_flag)
    );

    localparam logic [15:0] A_DIV = 16'hFF04;
    localparam logic [15:0] A_CNT = 16'hFF05;
    localparam logic [15:0] A_RLD = 16'hFF06;
    localparam logic [15:0] A_CTL = 16'hFF07;

    int vecs = 0;
    int bad  = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0] m_div, m_cnt, m_rld;
    logic [2:0] m_ctl;
    logic       m_irq;
    int         m_dsub, m_psc;

    function automatic int per(input logic [1:0] s);
        case (s)
            2'd0: return 1024;
            2'd1: return 16;
            2'd2: return 64;
            default: return 256;
        endcase
    endfunction

    task automatic cyc(input logic wr, input logic [15:0] a, input logic [7:0] d,
                       input logic tk, input logic ak);
        logic fire, wrp, dstep;
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk; irq_ack = ak;
        @(posedge clk);
        #1;
        fire  = m_ctl[2] && tk && (m_psc >= per(m_ctl[1:0]) - 1);
        wrp   = fire && (m_cnt == 8'hFF);
        dstep = tk && (m_dsub == 255);
        if (tk) m_dsub = dstep ? 0 : m_dsub + 1;
        if (wr && a == A_DIV) m_div = 8'h00;
        else if (dstep) m_div = m_div + 8'd1;
        if (m_ctl[2] && tk) m_psc = fire ? 0 : m_psc + 1;
        if (wr && a == A_CNT) m_cnt = d;
        else if (fire) m_cnt = wrp ? m_rld : m_cnt + 8'd1;
        if (wrp) m_irq = 1'b1;
        else if (ak) m_irq = 1'b0;
        if (wr && a == A_RLD) m_rld = d;
        if (wr && a == A_CTL) m_ctl = d[2:0];
        bus_wr = 1'b0; tick = 1'b0; irq_ack = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic chk(input logic [15:0] a, input logic [7:0] exp, input string tag);
        bus_wr = 1'b0; bus_addr = a;
        #0.1;
        vecs++;
        if (bus_rdata !== exp) begin
            bad++;
            $display("FAIL %s addr %h: actual %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        vecs++;
        if (irq_flag !== exp) begin
            bad++;
            $display("FAIL %s irq_flag: actual %b expected %b", tag, irq_flag, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(A_DIV, m_div, tag);
        chk(A_CNT, m_cnt, tag);
        chk_irq(m_irq, tag);
    endtask

    task automatic run(input int n, input logic tk, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 16'h0000, 8'h00, tk, 1'b0);
            chk_state(tag);
        end
    endtask

    task automatic wait_fire_next();
        while (m_psc < per(m_ctl[1:0]) - 1) cyc(1'b0, 16'h0000, 8'h00, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        m_div = 0; m_cnt = 0; m_rld = 0; m_ctl = 0; m_irq = 0; m_dsub = 0; m_psc = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;

        // R9 reset state
        chk(A_DIV, 8'h00, "R9");
        chk(A_CNT, 8'h00, "R9");
        chk(A_RLD, 8'h00, "R9");
        chk(A_CTL, 8'hF8, "R9 R5");
        chk_irq(1'b0, "R9");

        // R10 unmapped reads and stores
        chk(16'hFF03, 8'hFF, "R10");
        chk(16'hFF08, 8'hFF, "R10");
        chk(16'h0000, 8'hFF, "R10");
        cyc(1'b1, 16'hFF08, 8'h37, 1'b0, 1'b0);
        cyc(1'b1, 16'h0005, 8'h12, 1'b0, 1'b0);
        chk(A_CNT, 8'h00, "R10");
        chk(A_RLD, 8'h00, "R10");
        chk(A_CTL, 8'hF8, "R10");

        // R1 register stores, R5 control readback
        cyc(1'b1, A_RLD, 8'h40, 1'b0, 1'b0);
        chk(A_RLD, 8'h40, "R1");
        cyc(1'b1, A_CTL, 8'hAD, 1'b0, 1'b0);
        chk(A_CTL, 8'hFD, "R1 R5");
        cyc(1'b1, A_CNT, 8'h9C, 1'b0, 1'b0);
        chk(A_CNT, 8'h9C, "R1");

        // R4 R6 R7: every period select, through an overflow
        foreach (m_ctl[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [1:0] s;
            s = (k == 3) ? 2'd0 : 2'(k + 1);
            cyc(1'b1, A_CTL, {5'b0, 1'b1, s}, 1'b0, 1'b0);
            cyc(1'b1, A_CNT, 8'hFC, 1'b0, 1'b0);
            run(5 * per(s), 1'b1, "R4 R6 R7");
            chk_irq(1'b1, "R6");
            cyc(1'b0, 16'h0000, 8'h00, 1'b0, 1'b1);
            chk_irq(1'b0, "R8");
        end

        // R13 tick low freezes everything
        cyc(1'b1, A_CTL, 8'h05, 1'b0, 1'b0);
        run(50, 1'b0, "R13");
        run(40, 1'b1, "R13");

        // R11 disabled counter holds while divider runs
        cyc(1'b1, A_CTL, 8'h01, 1'b0, 1'b0);
        run(300, 1'b1, "R11");

        // R3 divider clear under ticking, sub-counter phase kept
        run(100, 1'b1, "R3");
        cyc(1'b1, A_DIV, 8'h5A, 1'b1, 1'b0);
        chk(A_DIV, 8'h00, "R3");
        run(600, 1'b1, "R3 R2");

        // R11 clear of divider leaves prescaler alone
        cyc(1'b1, A_CTL, 8'h06, 1'b0, 1'b0);
        run(37, 1'b1, "R11");
        cyc(1'b1, A_DIV, 8'h00, 1'b1, 1'b0);
        run(200, 1'b1, "R11");

        // R12 store on the same edge as a completed period (counter at 0xFF)
        cyc(1'b1, A_CTL, 8'h05, 1'b0, 1'b0);
        cyc(1'b1, A_CNT, 8'hFF, 1'b0, 1'b0);
        wait_fire_next();
        cyc(1'b1, A_CNT, 8'h33, 1'b1, 1'b0);
        chk(A_CNT, 8'h33, "R12");
        chk_irq(1'b1, "R12");
        cyc(1'b0, 16'h0000, 8'h00, 1'b0, 1'b1);
        chk_irq(1'b0, "R8");

        // R12 store against a non-wrapping increment
        cyc(1'b1, A_CNT, 8'h10, 1'b0, 1'b0);
        wait_fire_next();
        cyc(1'b1, A_CNT, 8'h80, 1'b1, 1'b0);
        chk(A_CNT, 8'h80, "R12");
        chk_irq(1'b0, "R12");

        // R8 acknowledge on the same edge as an overflow
        cyc(1'b1, A_CNT, 8'hFF, 1'b0, 1'b0);
        wait_fire_next();
        cyc(1'b0, 16'h0000, 8'h00, 1'b1, 1'b1);
        chk_irq(1'b1, "R8");
        chk(A_CNT, 8'h40, "R6");
        run(20, 1'b1, "R8");

        // R2 divider wraps through 0xFF
        cyc(1'b1, A_CTL, 8'h00, 1'b0, 1'b0);
        run(256 * 257, 1'b1, "R2");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule